// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status

This block is the arithmetic and logic core of a small 8-bit accumulator machine. It holds the accumulator and a five-bit flag register. Each cycle in which `op_valid` is high, it combines the accumulator with one external byte under a 4-bit operation code. The byte has already been chosen outside the block, from an immediate field, a register or memory. The result goes back into the accumulator, except for compare. The flags are sign, zero, half carry, even parity and carry. Borrow-aware subtraction, carry-chained adds, single-step increment and decrement, and four rotate forms cover what the instruction set needs. Multiplication, division and signed compare are left to software.

Both the accumulator and the flag register change on the rising clock edge after the operation is presented. Their new values show on `acc_o` and `flags_o` from that edge on. Flag bit positions are fixed: bit 4 sign, bit 3 zero, bit 2 half carry, bit 1 parity, bit 0 carry.

Operation codes: 0 NOP, 1 ADD, 2 ADC, 3 SUB, 4 SBB, 5 AND, 6 OR, 7 XOR, 8 CMP, 9 INC, 10 DEC, 11 RLC, 12 RRC, 13 RAL, 14 RAR, 15 LDA.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, the accumulator and all five flags are 0.
- R2: ADD (1) and ADC (2) write A + B, plus the stored carry for ADC, modulo 256 to the accumulator. Carry (bit 0) takes the carry out of bit 7.
- R3: SUB (3) and SBB (4) write A - B, minus the stored carry for SBB. Carry is 1 when a borrow out of bit 7 occurs.
- R4: Half carry (bit 2) is the carry from bit 3 into bit 4 for add and increment. For subtract, compare and decrement it is 1 when the low nibble needs a borrow.
- R5: For arithmetic, logic, compare, increment and decrement, sign (bit 4) equals bit 7 of the result, and zero (bit 3) is 1 when the result is 0. Parity (bit 1) is 1 when the result has an even number of ones.
- R6: AND (5), OR (6) and XOR (7) clear carry. AND sets half carry; OR and XOR clear it.
- R7: CMP (8) sets the flags exactly as SUB would and leaves the accumulator unchanged.
- R8: INC (9) and DEC (10) add or subtract one and update every flag except carry, which keeps its value.
- R9: RLC (11) and RRC (12) rotate left or right through bit 7 or bit 0. RAL (13) and RAR (14) rotate through carry. The bit shifted out lands in carry, and the other four flags keep their values.
- R10: NOP (0), or any code with `op_valid` low, changes neither the accumulator nor any flag.
- R11: LDA (15) copies the operand into the accumulator and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 4 | Operation select |
| operand | input | 8 | Second operand (B) |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | {sign, zero, half carry, parity, carry} |

## Verification
Add with carry is where two functions meet in one cycle: the stored carry from an earlier borrow enters the adder while the same result produces both a half carry and a full carry out. The bench sets carry with a borrowing subtract, then reloads the accumulator with LDA, which must keep that carry. It then adds 0x0F and 0xF0 with carry and expects 0x00 with zero, half carry, parity and carry all set. Compare is the other overlap: the flags update while the accumulator write is held off. The check is that the accumulator still reads its old value while the flags match the difference.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_ADC = 4'd2,
        OP_SUB = 4'd3,
        OP_SBB = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_CMP = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_RLC = 4'd11,
        OP_RRC = 4'd12,
        OP_RAL = 4'd13,
        OP_RAR = 4'd14,
        OP_LDA = 4'd15
    } op_e;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic hcy;
        logic par;
        logic cry;
    } flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         half_o
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   sum;
    logic [H:0]   low;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        c_eff  = sub_i ? ~cin_i : cin_i;
        sum    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low    = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
        res_o  = sum[W-1:0];
        cout_o = sum[W] ^ sub_i;
        half_o = low[H] ^ sub_i;
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] res_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                LG_AND:  res_o[i] = a_i[i] & b_i[i];
                LG_OR:   res_o[i] = a_i[i] | b_i[i];
                default: res_o[i] = a_i[i] ^ b_i[i];
            endcase
        end
    end
endmodule

// File: rtl/alu_rotator.sv
module alu_rotator #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         right_i,
    input  logic         thru_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic fill;

    always_comb begin
        if (right_i) begin
            fill   = thru_i ? cin_i : a_i[0];
            res_o  = {fill, a_i[W-1:1]};
            cout_o = a_i[0];
        end else begin
            fill   = thru_i ? cin_i : a_i[W-1];
            res_o  = {a_i[W-2:0], fill};
            cout_o = a_i[W-1];
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_o,
    output logic [4:0]        flags_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        flags_t            flg;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [DATA_W-1:0] as_b, as_res, lg_res, rt_res;
    logic              as_cin, as_sub, as_cout, as_half;
    logic              rt_right, rt_thru, rt_cout;
    logic_sel_e        lg_sel;

    assign op = op_e'(op_code);

    always_comb begin
        as_b   = operand;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:         as_cin = st_q.flg.cry;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = st_q.flg.cry;
            end
            OP_INC:         as_b = ONE;
            OP_DEC: begin
                as_b   = ONE;
                as_sub = 1'b1;
            end
            default: ;
        endcase

        unique case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            default: lg_sel = LG_XOR;
        endcase

        rt_right = (op == OP_RRC) || (op == OP_RAR);
        rt_thru  = (op == OP_RAL) || (op == OP_RAR);
    end

    alu_addsub #(.W(DATA_W)) i_addsub (
        .a_i   (st_q.acc),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .cout_o(as_cout),
        .half_o(as_half)
    );

    alu_bitwise #(.W(DATA_W)) i_bitwise (
        .a_i  (st_q.acc),
        .b_i  (operand),
        .sel_i(lg_sel),
        .res_o(lg_res)
    );

    alu_rotator #(.W(DATA_W)) i_rotator (
        .a_i    (st_q.acc),
        .cin_i  (st_q.flg.cry),
        .right_i(rt_right),
        .thru_i (rt_thru),
        .res_o  (rt_res),
        .cout_o (rt_cout)
    );

    function automatic flags_t result_flags(input logic [DATA_W-1:0] r,
                                            input logic h, input logic c);
        flags_t f;
        f.sgn = r[DATA_W-1];
        f.zro = (r == '0);
        f.hcy = h;
        f.par = ~^r;
        f.cry = c;
        return f;
    endfunction

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            unique case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                    st_d.acc = as_res;
                    st_d.flg = result_flags(as_res, as_half, as_cout);
                end
                OP_CMP: begin
                    st_d.flg = result_flags(as_res, as_half, as_cout);
                end
                OP_INC, OP_DEC: begin
                    st_d.acc = as_res;
                    st_d.flg = result_flags(as_res, as_half, st_q.flg.cry);
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.acc = lg_res;
                    st_d.flg = result_flags(lg_res, op == OP_AND, 1'b0);
                end
                OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                    st_d.acc     = rt_res;
                    st_d.flg.cry = rt_cout;
                end
                OP_LDA: st_d.acc = operand;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o   = st_q.acc;
    assign flags_o = st_q.flg;
endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc_o,
    input logic [4:0]        flags_o
);
    logic idle, is_cmp, is_incdec, is_logic, is_rot, is_lda, sets_zsp;

    assign idle      = !op_valid || (op_code == OP_NOP);
    assign is_cmp    = op_valid && (op_code == OP_CMP);
    assign is_incdec = op_valid && (op_code == OP_INC || op_code == OP_DEC);
    assign is_logic  = op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR);
    assign is_rot    = op_valid && (op_code >= OP_RLC) && (op_code <= OP_RAR);
    assign is_lda    = op_valid && (op_code == OP_LDA);
    assign sets_zsp  = op_valid && (op_code != OP_NOP) && (op_code != OP_CMP)
                       && (op_code < OP_RLC);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(acc_o) && $stable(flags_o));

    assert_cmp_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> $stable(acc_o));

    assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_incdec |=> flags_o[0] == $past(flags_o[0]));

    assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> flags_o[0] == 1'b0);

    assert_rot_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_rot |=> $stable(flags_o[4:1]));

    assert_lda_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_lda |=> (acc_o == $past(operand)) && $stable(flags_o));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sets_zsp |=> flags_o[3] == (acc_o == '0));

    assert_sign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sets_zsp |=> flags_o[4] == acc_o[DATA_W-1]);
endmodule

bind acc_alu_core alu_core_checker #(.DATA_W(DATA_W)) i_alu_core_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op_code (op_code),
    .operand (operand),
    .acc_o   (acc_o),
    .flags_o (flags_o)
);

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc_o;
    logic [4:0] flags_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_acc = 8'd0;
    logic [4:0] m_fl = 5'd0;

    always #2 clk = ~clk;

    acc_alu_core i_acc_alu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .acc_o(acc_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [7:0] ea, input logic [4:0] ef);
        n_chk++;
        if (acc_o !== ea || flags_o !== ef) begin
            n_fail++;
            $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                     tag, acc_o, flags_o, ea, ef);
        end
    endtask

    function automatic logic [4:0] zsp(input logic [7:0] r, input logic h, input logic c);
        return {r[7], r == 8'd0, h, ~^r, c};
    endfunction

    task automatic model(input logic v, input logic [3:0] op, input logic [7:0] b);
        logic [8:0] w;
        logic       c, h;
        logic [7:0] r;
        c = m_fl[0];
        if (v) begin
            case (op)
                4'd1, 4'd2: begin
                    w = m_acc + b + ((op == 4'd2) ? c : 1'b0);
                    h = (m_acc[3:0] + b[3:0] + ((op == 4'd2) ? c : 1'b0)) > 15;
                    m_acc = w[7:0]; m_fl = zsp(w[7:0], h, w[8]);
                end
                4'd3, 4'd4, 4'd8: begin
                    w = {1'b0, m_acc} - {1'b0, b} - ((op == 4'd4) ? c : 1'b0);
                    h = {1'b0, m_acc[3:0]} < ({1'b0, b[3:0]} + ((op == 4'd4) ? c : 1'b0));
                    if (op != 4'd8) m_acc = w[7:0];
                    m_fl = zsp(w[7:0], h, w[8]);
                end
                4'd5: begin m_acc = m_acc & b; m_fl = zsp(m_acc, 1'b1, 1'b0); end
                4'd6: begin m_acc = m_acc | b; m_fl = zsp(m_acc, 1'b0, 1'b0); end
                4'd7: begin m_acc = m_acc ^ b; m_fl = zsp(m_acc, 1'b0, 1'b0); end
                4'd9: begin
                    h = (m_acc[3:0] == 4'hF); m_acc = m_acc + 8'd1; m_fl = zsp(m_acc, h, c);
                end
                4'd10: begin
                    h = (m_acc[3:0] == 4'h0); m_acc = m_acc - 8'd1; m_fl = zsp(m_acc, h, c);
                end
                4'd11: begin r = {m_acc[6:0], m_acc[7]}; m_fl[0] = m_acc[7]; m_acc = r; end
                4'd12: begin r = {m_acc[0], m_acc[7:1]}; m_fl[0] = m_acc[0]; m_acc = r; end
                4'd13: begin r = {m_acc[6:0], c}; m_fl[0] = m_acc[7]; m_acc = r; end
                4'd14: begin r = {c, m_acc[7:1]}; m_fl[0] = m_acc[0]; m_acc = r; end
                4'd15: m_acc = b;
                default: ;
            endcase
        end
    endtask

    task automatic do_op(input logic v, input logic [3:0] op, input logic [7:0] b);
        @(negedge clk);
        op_valid = v; op_code = op; operand = b;
        @(negedge clk);
        op_valid = 1'b0;
        model(v, op, b);
    endtask

    task automatic t_reset;
        check("R1 reset", 8'h00, 5'b00000);
    endtask

    task automatic t_add;
        do_op(1, 4'd15, 8'h3A); check("R11 load", 8'h3A, 5'b00000);
        do_op(1, 4'd1, 8'h46);  check("R2 R4 R5 add half carry", 8'h80, 5'b10100);
        do_op(1, 4'd1, 8'h80);  check("R2 add carry out", 8'h00, 5'b01011);
        do_op(1, 4'd2, 8'h10);  check("R2 adc uses carry", 8'h11, 5'b00010);
    endtask

    task automatic t_sub;
        do_op(1, 4'd15, 8'h10);
        do_op(1, 4'd3, 8'h01); check("R3 R4 sub nibble borrow", 8'h0F, 5'b00110);
        do_op(1, 4'd3, 8'h20); check("R3 sub borrow", 8'hEF, 5'b10001);
        do_op(1, 4'd4, 8'h00); check("R3 sbb uses borrow", 8'hEE, 5'b10010);
    endtask

    task automatic t_logic;
        do_op(1, 4'd15, 8'hF0);
        do_op(1, 4'd5, 8'h3C); check("R6 and", 8'h30, 5'b00110);
        do_op(1, 4'd6, 8'h0F); check("R6 or", 8'h3F, 5'b00010);
        do_op(1, 4'd7, 8'h3F); check("R6 R5 xor zero", 8'h00, 5'b01010);
    endtask

    task automatic t_cmp;
        do_op(1, 4'd15, 8'h05);
        do_op(1, 4'd8, 8'h07); check("R7 cmp less", 8'h05, 5'b10101);
        do_op(1, 4'd8, 8'h05); check("R7 cmp equal", 8'h05, 5'b01010);
    endtask

    task automatic t_incdec;
        do_op(1, 4'd8, 8'h07);
        do_op(1, 4'd15, 8'hFF);
        do_op(1, 4'd9, 8'h00);  check("R8 inc wrap keeps carry", 8'h00, 5'b01111);
        do_op(1, 4'd10, 8'h00); check("R8 dec wrap keeps carry", 8'hFF, 5'b10111);
        do_op(1, 4'd7, 8'h00);
        do_op(1, 4'd10, 8'h00); check("R8 R4 dec no nibble borrow", 8'hFE, 5'b10000);
    endtask

    task automatic t_rot;
        do_op(1, 4'd15, 8'h81);
        do_op(1, 4'd11, 8'h00); check("R9 rlc", 8'h03, 5'b10001);
        do_op(1, 4'd13, 8'h00); check("R9 ral", 8'h07, 5'b10000);
        do_op(1, 4'd12, 8'h00); check("R9 rrc", 8'h83, 5'b10001);
        do_op(1, 4'd14, 8'h00); check("R9 rar", 8'hC1, 5'b10001);
    endtask

    task automatic t_idle;
        do_op(0, 4'd1, 8'h55); check("R10 valid low", 8'hC1, 5'b10001);
        do_op(1, 4'd0, 8'h55); check("R10 nop", 8'hC1, 5'b10001);
    endtask

    task automatic t_chain;
        do_op(1, 4'd15, 8'h00);
        do_op(1, 4'd3, 8'h01);  check("R3 borrow from zero", 8'hFF, 5'b10111);
        do_op(1, 4'd15, 8'h0F); check("R11 flags kept", 8'h0F, 5'b10111);
        do_op(1, 4'd2, 8'hF0);  check("R2 R4 adc full chain", 8'h00, 5'b01111);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 300; i++) begin
            do_op(($urandom % 8) != 0, 4'($urandom), 8'($urandom));
            check("R5 sweep", m_acc, m_fl);
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_add;
        t_sub;
        t_logic;
        t_cmp;
        t_incdec;
        t_rot;
        t_idle;
        t_chain;
        t_sweep;
        done = 1'b1;
        finish_up;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            finish_up;
        end
    end
endmodule